// File: doc/BRIEF.md
# Signed Integer Encoding Converter

This block rewrites a signed integer from one machine encoding into another. It handles four encodings: sign-magnitude, ones' complement, two's complement and biased (offset) code. The word is `MAG_W + 1` bits wide, with the top bit acting as the sign or bias bit. Two 2-bit selects pick the source and the destination encoding. The block first turns the source word into two's complement, which serves as a common pivot form. It then re-encodes that pivot into the destination encoding.

The path from two's complement back to a magnitude uses the serial rule. A combinational scan starts at the least significant bit and keeps every bit up to and including the first 1. Every higher magnitude bit is inverted. Two encodings have a duplicate zero, and both zeros are folded into the destination's single zero pattern. The one value that two's complement and biased code can hold but the symmetric encodings cannot is reported as unrepresentable.

The result is registered once, so a converted word and its two flags appear one clock after the inputs are sampled.

Top module: `encconv`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `conv_out`, `unrep_flag` and `negz_flag` are all zero.
- R2: The outputs at each rising clock edge reflect the inputs sampled at that edge, so they become visible one cycle after the inputs are applied.
- R3: Select code 0 is sign-magnitude: the MSB is 1 for negative and 0 for positive, and the lower `MAG_W` bits hold the absolute value.
- R4: Select code 1 is ones' complement: a negative value has MSB 1 and every magnitude bit of its absolute value inverted.
- R5: Select code 2 is two's complement. Converting a negative two's complement word to sign-magnitude keeps the bits up to and including the lowest 1 and inverts the higher magnitude bits.
- R6: Select code 3 is biased code, which equals the two's complement word with its MSB inverted. Its MSB is 1 for values of zero or above.
- R7: A negative-zero input produces the destination's single zero pattern and raises `negz_flag`. For sign-magnitude the negative-zero input is 1 followed by zeros, and for ones' complement it is all ones. The zero pattern is all zeros, except for biased code, where it is 1 followed by zeros. For every other input `negz_flag` is low.
- R8: Converting the value -2^MAG_W into sign-magnitude or ones' complement raises `unrep_flag` and forces `conv_out` to zero. That value is 1 followed by zeros in two's complement, or all zeros in biased code.
- R9: When source and destination selects are equal, the output equals the input, except for a negative-zero input.
- R10: `unrep_flag` and `negz_flag` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_in | input | MAG_W+1 | Source word |
| src_sel | input | 2 | Source encoding (0 sign-magnitude, 1 ones', 2 two's, 3 biased) |
| dst_sel | input | 2 | Destination encoding, same codes |
| conv_out | output | MAG_W+1 | Converted word, registered |
| unrep_flag | output | 1 | Result value cannot be held by the destination |
| negz_flag | output | 1 | Input was a negative zero |

## Verification
The bench builds two copies of the block, one with `MAG_W = 7` and one with `MAG_W = 3`. Each copy is swept over every input word under all sixteen source and destination pairs, so both zero duplicates, both range ends and the lone unrepresentable minimum are reached at each width. The narrow copy cycles through its space many times while the wide one is swept once. As a result, carry and scan chains of different lengths are compared against an integer-valued model in the same run.

// File: rtl/encconv_pkg.sv
package encconv_pkg;

  typedef enum logic [1:0] {
    ENC_SMAG   = 2'd0,
    ENC_ONES   = 2'd1,
    ENC_TWOS   = 2'd2,
    ENC_BIASED = 2'd3
  } enc_e;

endpackage

// File: rtl/encconv_decode.sv
module encconv_decode
  import encconv_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W:0] word_i,
  input  logic [1:0]     src_i,
  output logic [MAG_W:0] pivot_o,
  output logic           negz_o
);
  localparam int W = MAG_W + 1;

  function automatic logic [W-1:0] negate(input logic [W-1:0] x);
    return (~x) + {{(W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [W-1:0] from_smag(input logic [W-1:0] x);
    if (x[W-1]) return negate({1'b0, x[W-2:0]});
    return x;
  endfunction

  function automatic logic [W-1:0] from_ones(input logic [W-1:0] x);
    if (x[W-1]) return x + {{(W-1){1'b0}}, 1'b1};
    return x;
  endfunction

  logic sign_bit;
  logic low_zero;
  logic low_ones;

  assign sign_bit = word_i[W-1];
  assign low_zero = (word_i[W-2:0] == '0);
  assign low_ones = (word_i[W-2:0] == {(W-1){1'b1}});

  always_comb begin
    pivot_o = word_i;
    negz_o  = 1'b0;
    unique case (enc_e'(src_i))
      ENC_SMAG: begin
        pivot_o = from_smag(word_i);
        negz_o  = sign_bit & low_zero;
      end
      ENC_ONES: begin
        pivot_o = from_ones(word_i);
        negz_o  = sign_bit & low_ones;
      end
      ENC_TWOS:   pivot_o = word_i;
      ENC_BIASED: pivot_o = {~sign_bit, word_i[W-2:0]};
      default:    pivot_o = word_i;
    endcase
  end
endmodule

// File: rtl/encconv_serial_mag.sv
module encconv_serial_mag #(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W:0]   twos_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             is_min_o
);
  logic neg;
  logic [MAG_W:0] seen;

  assign neg     = twos_i[MAG_W];
  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < MAG_W; i++) begin : g_scan
      assign mag_o[i]    = neg ? (twos_i[i] ^ seen[i]) : twos_i[i];
      assign seen[i + 1] = seen[i] | twos_i[i];
    end
  endgenerate

  assign is_min_o = neg & ~seen[MAG_W];
endmodule

// File: rtl/encconv_encode.sv
module encconv_encode
  import encconv_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W:0] pivot_i,
  input  logic [1:0]     dst_i,
  output logic [MAG_W:0] word_o,
  output logic           unrep_o
);
  localparam int W = MAG_W + 1;

  logic [MAG_W-1:0] mag;
  logic             is_min;
  logic             neg;
  logic             sym_dst;

  encconv_serial_mag #(.MAG_W(MAG_W)) u_scan (
    .twos_i  (pivot_i),
    .mag_o   (mag),
    .is_min_o(is_min)
  );

  function automatic logic [W-1:0] to_smag(input logic n, input logic [W-2:0] m);
    return {n, m};
  endfunction

  function automatic logic [W-1:0] to_ones(input logic n, input logic [W-2:0] m);
    return n ? {1'b1, ~m} : {1'b0, m};
  endfunction

  assign neg     = pivot_i[W-1];
  assign sym_dst = (enc_e'(dst_i) == ENC_SMAG) || (enc_e'(dst_i) == ENC_ONES);
  assign unrep_o = sym_dst & is_min;

  always_comb begin
    word_o = pivot_i;
    unique case (enc_e'(dst_i))
      ENC_SMAG:   word_o = to_smag(neg, mag);
      ENC_ONES:   word_o = to_ones(neg, mag);
      ENC_TWOS:   word_o = pivot_i;
      ENC_BIASED: word_o = {~neg, pivot_i[W-2:0]};
      default:    word_o = pivot_i;
    endcase
    if (unrep_o) word_o = '0;
  end
endmodule

// File: rtl/encconv.sv
module encconv #(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W:0]   conv_in,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       dst_sel,
  output logic [MAG_W:0]   conv_out,
  output logic             unrep_flag,
  output logic             negz_flag
);
  logic [MAG_W:0] pivot;
  logic           dec_negz;
  logic [MAG_W:0] enc_word;
  logic           enc_unrep;

  encconv_decode #(.MAG_W(MAG_W)) u_dec (
    .word_i (conv_in),
    .src_i  (src_sel),
    .pivot_o(pivot),
    .negz_o (dec_negz)
  );

  encconv_encode #(.MAG_W(MAG_W)) u_enc (
    .pivot_i(pivot),
    .dst_i  (dst_sel),
    .word_o (enc_word),
    .unrep_o(enc_unrep)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_out   <= '0;
      unrep_flag <= 1'b0;
      negz_flag  <= 1'b0;
    end else begin
      conv_out   <= enc_word;
      unrep_flag <= enc_unrep;
      negz_flag  <= dec_negz;
    end
  end
endmodule

// File: rtl/encconv_chk.sv
module encconv_chk #(
  parameter int MAG_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [MAG_W:0] conv_in,
  input logic [1:0]     src_sel,
  input logic [1:0]     dst_sel,
  input logic [MAG_W:0] conv_out,
  input logic           unrep_flag,
  input logic           negz_flag,
  input logic           dec_negz,
  input logic           enc_unrep
);
  localparam logic [MAG_W:0] BIAS_ZERO = {1'b1, {MAG_W{1'b0}}};

  // R8
  unrep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unrep_flag |-> (conv_out == '0));

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unrep_flag && negz_flag));

  // R7
  negz_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_negz |=> (negz_flag &&
      (conv_out == (($past(dst_sel) == 2'd3) ? BIAS_ZERO : '0))));

  // R8
  unrep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_unrep |=> unrep_flag);

  // R9
  same_pivot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel == dst_sel) && src_sel[1]) |=> (conv_out == $past(conv_in)));

  // R6
  twos_to_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel == 2'd2) && (dst_sel == 2'd3)) |=>
      (conv_out == {~$past(conv_in[MAG_W]), $past(conv_in[MAG_W-1:0])}));
endmodule

bind encconv encconv_chk #(.MAG_W(MAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_in   (conv_in),
  .src_sel   (src_sel),
  .dst_sel   (dst_sel),
  .conv_out  (conv_out),
  .unrep_flag(unrep_flag),
  .negz_flag (negz_flag),
  .dec_negz  (dec_negz),
  .enc_unrep (enc_unrep)
);

// File: tb/encconv_tb.sv
module encconv_tb;
  localparam int CLK_P = 10;
  localparam int MW_A  = 7;
  localparam int MW_B  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic [MW_A:0] in_a = '0, out_a;
  logic [1:0]    src_a = '0, dst_a = '0;
  logic          unrep_a, negz_a;
  logic [MW_B:0] in_b = '0, out_b;
  logic [1:0]    src_b = '0, dst_b = '0;
  logic          unrep_b, negz_b;

  encconv #(.MAG_W(MW_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_in(in_a), .src_sel(src_a), .dst_sel(dst_a),
    .conv_out(out_a), .unrep_flag(unrep_a), .negz_flag(negz_a));

  encconv #(.MAG_W(MW_B)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .conv_in(in_b), .src_sel(src_b), .dst_sel(dst_b),
    .conv_out(out_b), .unrep_flag(unrep_b), .negz_flag(negz_b));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference: word -> integer value
  function automatic int ref_value(int w, int src, int mw, output bit negz);
    int s, m, full;
    full = 1 << (mw + 1);
    s = (w >> mw) & 1;
    negz = 0;
    case (src)
      0: begin m = w & ((1 << mw) - 1); negz = (s == 1) && (m == 0); return s ? -m : m; end
      1: begin m = (~w) & ((1 << mw) - 1); if (s == 0) return w; negz = (m == 0); return -m; end
      2: return s ? w - full : w;
      default: return w - (1 << mw);
    endcase
  endfunction

  // Reference: integer value -> word
  function automatic int ref_word(int v, int dst, int mw, output bit unrep);
    int maskw;
    maskw = (1 << (mw + 1)) - 1;
    unrep = 0;
    if ((dst < 2) && (v == -(1 << mw))) begin unrep = 1; return 0; end
    case (dst)
      0: return (v < 0) ? ((1 << mw) | -v) : v;
      1: return (v < 0) ? (maskw ^ -v) : v;
      2: return v & maskw;
      default: return (v + (1 << mw)) & maskw;
    endcase
  endfunction

  function automatic string tag_of(int src, int dst, bit negz, bit unrep);
    if (negz) return "R7";
    if (unrep) return "R8";
    if (src == dst) return "R9";
    case (src)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  int exp_a_w, exp_b_w;
  bit exp_a_u, exp_a_n, exp_b_u, exp_b_n;
  string tag_a, tag_b;

  task automatic compare(string inst, string tag, int got_w, int exp_w,
                         bit got_u, bit exp_u, bit got_n, bit exp_n);
    n_cmp++;
    if (got_w != exp_w || got_u != exp_u || got_n != exp_n) begin
      n_bad++;
      $display("FAIL %s R2/%s: out=%0h unrep=%0b negz=%0b expected out=%0h unrep=%0b negz=%0b",
               inst, tag, got_w, got_u, got_n, exp_w, exp_u, exp_n);
    end
  endtask

  task automatic predict(int idx);
    bit n, u;
    int v;
    in_a  = idx[MW_A:0];
    src_a = idx[MW_A+2:MW_A+1];
    dst_a = idx[MW_A+4:MW_A+3];
    v = ref_value(int'(in_a), int'(src_a), MW_A, n);
    exp_a_w = ref_word(v, int'(dst_a), MW_A, u);
    exp_a_n = n; exp_a_u = u;
    tag_a = tag_of(int'(src_a), int'(dst_a), n, u);
    in_b  = idx[MW_B:0];
    src_b = idx[MW_B+2:MW_B+1];
    dst_b = idx[MW_B+4:MW_B+3];
    v = ref_value(int'(in_b), int'(src_b), MW_B, n);
    exp_b_w = ref_word(v, int'(dst_b), MW_B, u);
    exp_b_n = n; exp_b_u = u;
    tag_b = tag_of(int'(src_b), int'(dst_b), n, u);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare("wide", "R1", int'(out_a), 0, unrep_a, 1'b0, negz_a, 1'b0);
    compare("narrow", "R1", int'(out_b), 0, unrep_b, 1'b0, negz_b, 1'b0);
    rst_n = 1'b1;
    predict(0);
    for (int idx = 1; idx <= (1 << (MW_A + 5)); idx++) begin
      @(negedge clk);
      compare("wide", tag_a, int'(out_a), exp_a_w, unrep_a, exp_a_u, negz_a, exp_a_n);
      compare("narrow", tag_b, int'(out_b), exp_b_w, unrep_b, exp_b_u, negz_b, exp_b_n);
      // R10: the flags never rise together
      n_cmp++;
      if ((unrep_a && negz_a) || (unrep_b && negz_b)) begin
        n_bad++;
        $display("FAIL R10: unrep=%0b/%0b negz=%0b/%0b expected not both high",
                 unrep_a, unrep_b, negz_a, negz_b);
      end
      if (idx < (1 << (MW_A + 5))) predict(idx);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule